// File: doc/BRIEF.md
# I2C Bus Status Flag Tracker

This block sits beside an I2C peripheral and watches the SCL and SDA lines, which it samples through a synchronizer chain of its own. It recognises start and stop conditions, counts the SCL rising edges within each byte to find the acknowledge (9th) clock, and knows whether the byte in progress is the address byte that follows a start. From these events it keeps four status flags: acknowledge seen, start seen (address phase), stop seen (bus released), and the transmit/receive direction.

The flags are cleared by events at defined byte positions, by a communication-release pulse, by a fall of the wakeup-mode bit, and by the peripheral enable. When the clock stretch at the acknowledge slot is released by a stretch-release pulse while the block is transmitting, the direction returns to receive and a one-cycle SDA-release pulse tells the line driver to let SDA float. A release by a shift-register write keeps the transmit state.

Top module: `i2c_flag_tracker`

## Requirements
- R1: A start condition (SDA falls while SCL is high) sets `start_det`; a stop condition (SDA rises while SCL is high) sets `stop_det` and clears `start_det`, `ack_det` and `tx_mode`.
- R2: `ack_det` becomes 1 when SDA is low at the 9th SCL rising edge of a byte, and stays 0 when SDA is high there.
- R3: `ack_det` clears at the first SCL rising edge of the next byte.
- R4: `start_det` stays 1 through the address byte and its acknowledge, and clears at the first SCL rising edge of the byte after the address byte.
- R5: `stop_det` stays 1 across a new start condition and clears at the first SCL rising edge of the address byte that follows it.
- R6: A `comm_release` pulse clears `ack_det`, `start_det` and `tx_mode` and leaves `stop_det` unchanged.
- R7: A 1-to-0 change of `wake_mode` clears `stop_det`; a 0-to-1 change leaves it unchanged.
- R8: After reset all flags and `sda_release` are 0; while `enable` is 0 they are held at 0 and bus events are ignored.
- R9: `tx_mode` takes the value of SDA at the 8th SCL rising edge of the address byte (1 = transmit); a start condition clears it.
- R10: A `stretch_release` pulse while the byte counter sits after the 9th clock and `tx_mode` is 1 clears `tx_mode` and raises `sda_release` for exactly one cycle; with `tx_mode` at 0 it produces no pulse.
- R11: A `shreg_write` pulse in the acknowledge slot, alone or together with `stretch_release`, leaves `tx_mode` at 1 and produces no `sda_release` pulse.
- R12: When a set event and a clear event other than reset or disable fall on the same cycle, the set wins (a start condition together with `comm_release` leaves `start_det` at 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_in | input | 1 | SCL line level, asynchronous |
| sda_in | input | 1 | SDA line level, asynchronous |
| enable | input | 1 | Peripheral enable; 0 clears and holds all flags |
| wake_mode | input | 1 | Wakeup-mode bit; its fall clears the stop flag |
| comm_release | input | 1 | One-cycle pulse: leave the current transfer |
| stretch_release | input | 1 | One-cycle pulse: release the acknowledge-slot stretch |
| shreg_write | input | 1 | One-cycle pulse: shift register written (stretch release that keeps transmit) |
| ack_det | output | 1 | Acknowledge detected |
| start_det | output | 1 | Start detected, address phase in progress |
| stop_det | output | 1 | Stop detected, bus released |
| tx_mode | output | 1 | Direction: 1 transmit, 0 receive |
| sda_release | output | 1 | One-cycle pulse: float SDA |

## Verification
A change on a bus line passes through the two synchronizer stages and one edge register, so the flag it affects changes at the third rising clock edge after the line moves; the bench holds every line level for four clocks and samples on the falling edge after that, so each check lands after the update and before the next stimulus. The control pulses are not synchronized: `comm_release`, `stretch_release`, `shreg_write` and a `wake_mode` fall act at the first rising edge that sees them, and `sda_release` is high only for the cycle after that edge, so the bench samples on the following falling edge and again one cycle later. The same-cycle priority case aligns `comm_release` with the edge at which the start condition is registered by counting exactly the synchronizer depth in falling edges.

// File: rtl/i2c_flag_pkg.sv
package i2c_flag_pkg;

   // Bus events decoded from the synchronized lines, valid for one cycle.
   typedef struct packed {
      logic start;
      logic stop;
      logic scl_rise;
   } bus_evt_t;

   // Status flags kept by the tracker.
   typedef struct packed {
      logic ack;
      logic start;
      logic stop;
      logic tx;
   } flags_t;

   localparam int unsigned MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/line_sync.sv
module line_sync #(
   parameter int unsigned STAGES    = 2,
   parameter bit          IDLE_LEVEL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic q_out
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < i2c_flag_pkg::MIN_SYNC_STAGES) begin : g_bad_depth
         $error("line_sync: STAGES below minimum");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               chain[s] <= IDLE_LEVEL;
            else if (s == 0)
               chain[s] <= d_in;
            else
               chain[s] <= chain[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q_out = chain[STAGES-1];
endmodule

// File: rtl/bus_event_detect.sv
module bus_event_detect
   import i2c_flag_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     scl_s,
   input  logic     sda_s,
   output bus_evt_t evt
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   always_comb begin
      evt.scl_rise = scl_s & ~scl_q;
      evt.start    = scl_s & scl_q & sda_q & ~sda_s;
      evt.stop     = scl_s & scl_q & ~sda_q & sda_s;
   end
endmodule

// File: rtl/byte_position.sv
module byte_position
   import i2c_flag_pkg::*;
#(
   parameter int unsigned CLOCKS_PER_BYTE = 9,
   parameter int unsigned RW_CLOCK        = 8,
   localparam int unsigned CNT_W          = $clog2(CLOCKS_PER_BYTE + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  bus_evt_t         evt,
   output logic [CNT_W-1:0] bit_cnt,
   output logic             ack_clk,
   output logic             rw_clk,
   output logic             first_clk,
   output logic             addr_first_clk,
   output logic             leave_addr,
   output logic             in_ack_slot
);
   localparam logic [CNT_W-1:0] LAST  = CNT_W'(CLOCKS_PER_BYTE);
   localparam logic [CNT_W-1:0] PRE_A = CNT_W'(CLOCKS_PER_BYTE - 1);
   localparam logic [CNT_W-1:0] PRE_R = CNT_W'(RW_CLOCK - 1);

   logic addr_byte;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt   <= '0;
         addr_byte <= 1'b0;
      end else if (!enable) begin
         bit_cnt   <= '0;
         addr_byte <= 1'b0;
      end else if (evt.start) begin
         bit_cnt   <= '0;
         addr_byte <= 1'b1;
      end else if (evt.scl_rise) begin
         if (bit_cnt == LAST) begin
            bit_cnt   <= CNT_W'(1);
            addr_byte <= 1'b0;
         end else begin
            bit_cnt <= bit_cnt + CNT_W'(1);
         end
      end
   end

   always_comb begin
      ack_clk        = evt.scl_rise && (bit_cnt == PRE_A);
      rw_clk         = evt.scl_rise && addr_byte && (bit_cnt == PRE_R);
      first_clk      = evt.scl_rise && ((bit_cnt == '0) || (bit_cnt == LAST));
      addr_first_clk = evt.scl_rise && addr_byte && (bit_cnt == '0);
      leave_addr     = evt.scl_rise && addr_byte && (bit_cnt == LAST);
      in_ack_slot    = (bit_cnt == LAST);
   end
endmodule

// File: rtl/flag_regs.sv
module flag_regs
   import i2c_flag_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     enable,
   input  logic     wake_mode,
   input  logic     comm_release,
   input  logic     stretch_release,
   input  logic     shreg_write,
   input  bus_evt_t evt,
   input  logic     sda_s,
   input  logic     ack_clk,
   input  logic     rw_clk,
   input  logic     first_clk,
   input  logic     addr_first_clk,
   input  logic     leave_addr,
   input  logic     in_ack_slot,
   output flags_t   flags,
   output logic     sda_release
);
   logic wake_q;
   logic wake_fall;
   logic rx_return;

   assign wake_fall = wake_q & ~wake_mode;
   assign rx_return = stretch_release & ~shreg_write & in_ack_slot & flags.tx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wake_q <= 1'b0;
      else        wake_q <= wake_mode;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags       <= '0;
         sda_release <= 1'b0;
      end else if (!enable) begin
         flags       <= '0;
         sda_release <= 1'b0;
      end else begin
         if (ack_clk && !sda_s)                        flags.ack <= 1'b1;
         else if (evt.stop || first_clk || comm_release) flags.ack <= 1'b0;

         if (evt.start)                                   flags.start <= 1'b1;
         else if (evt.stop || leave_addr || comm_release) flags.start <= 1'b0;

         if (evt.stop)                              flags.stop <= 1'b1;
         else if (addr_first_clk || wake_fall)      flags.stop <= 1'b0;

         if (rw_clk)                                flags.tx <= sda_s;
         else if (evt.start || evt.stop || comm_release || rx_return)
                                                    flags.tx <= 1'b0;

         sda_release <= rx_return;
      end
   end
endmodule

// File: rtl/i2c_flag_tracker.sv
module i2c_flag_tracker
   import i2c_flag_pkg::*;
#(
   parameter int unsigned SYNC_STAGES     = 2,
   parameter int unsigned CLOCKS_PER_BYTE = 9,
   parameter int unsigned RW_CLOCK        = 8,
   localparam int unsigned CNT_W          = $clog2(CLOCKS_PER_BYTE + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   input  logic enable,
   input  logic wake_mode,
   input  logic comm_release,
   input  logic stretch_release,
   input  logic shreg_write,
   output logic ack_det,
   output logic start_det,
   output logic stop_det,
   output logic tx_mode,
   output logic sda_release
);
   generate
      if (RW_CLOCK == 0 || RW_CLOCK >= CLOCKS_PER_BYTE) begin : g_bad_rw
         $error("i2c_flag_tracker: RW_CLOCK must lie inside the byte");
      end
      if (CLOCKS_PER_BYTE < 2) begin : g_bad_cpb
         $error("i2c_flag_tracker: CLOCKS_PER_BYTE too small");
      end
   endgenerate

   logic             scl_s, sda_s;
   bus_evt_t         evt;
   flags_t           flags;
   logic [CNT_W-1:0] bit_cnt;
   logic             ack_clk, rw_clk, first_clk, addr_first_clk, leave_addr, in_ack_slot;
   logic             ev_start, ev_stop, ev_scl_rise;

   line_sync #(.STAGES(SYNC_STAGES), .IDLE_LEVEL(1'b1)) i_scl_sync (
      .clk(clk), .rst_n(rst_n), .d_in(scl_in), .q_out(scl_s));
   line_sync #(.STAGES(SYNC_STAGES), .IDLE_LEVEL(1'b1)) i_sda_sync (
      .clk(clk), .rst_n(rst_n), .d_in(sda_in), .q_out(sda_s));

   bus_event_detect i_evt (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s), .evt(evt));

   byte_position #(.CLOCKS_PER_BYTE(CLOCKS_PER_BYTE), .RW_CLOCK(RW_CLOCK)) i_pos (
      .clk(clk), .rst_n(rst_n), .enable(enable), .evt(evt),
      .bit_cnt(bit_cnt), .ack_clk(ack_clk), .rw_clk(rw_clk),
      .first_clk(first_clk), .addr_first_clk(addr_first_clk),
      .leave_addr(leave_addr), .in_ack_slot(in_ack_slot));

   flag_regs i_flags (
      .clk(clk), .rst_n(rst_n), .enable(enable), .wake_mode(wake_mode),
      .comm_release(comm_release), .stretch_release(stretch_release),
      .shreg_write(shreg_write), .evt(evt), .sda_s(sda_s),
      .ack_clk(ack_clk), .rw_clk(rw_clk), .first_clk(first_clk),
      .addr_first_clk(addr_first_clk), .leave_addr(leave_addr),
      .in_ack_slot(in_ack_slot), .flags(flags), .sda_release(sda_release));

   assign ev_start    = evt.start;
   assign ev_stop     = evt.stop;
   assign ev_scl_rise = evt.scl_rise;

   assign ack_det   = flags.ack;
   assign start_det = flags.start;
   assign stop_det  = flags.stop;
   assign tx_mode   = flags.tx;
endmodule

// File: rtl/i2c_flag_tracker_chk.sv
module i2c_flag_tracker_chk #(
   parameter int unsigned CLOCKS_PER_BYTE = 9,
   parameter int unsigned CNT_W           = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             enable,
   input logic             wake_mode,
   input logic             stretch_release,
   input logic             shreg_write,
   input logic             ev_start,
   input logic             ev_stop,
   input logic             ev_scl_rise,
   input logic             sda_s,
   input logic [CNT_W-1:0] bit_cnt,
   input logic             ack_det,
   input logic             start_det,
   input logic             stop_det,
   input logic             tx_mode,
   input logic             sda_release
);
   localparam logic [CNT_W-1:0] LAST  = CNT_W'(CLOCKS_PER_BYTE);
   localparam logic [CNT_W-1:0] PRE_A = CNT_W'(CLOCKS_PER_BYTE - 1);

   p_start_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
      enable && ev_start |=> start_det);

   p_stop_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
      enable && ev_stop |=> stop_det && !start_det && !ack_det && !tx_mode);

   p_ack_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      enable && ev_scl_rise && bit_cnt == PRE_A && !sda_s |=> ack_det);

   p_ack_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      enable && ev_scl_rise && bit_cnt == LAST |=> !ack_det);

   p_wake_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      enable && $fell(wake_mode) && !ev_stop |=> !stop_det);

   p_disable_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !ack_det && !start_det && !stop_det && !tx_mode && !sda_release);

   p_release_dir_r10: assert property (@(posedge clk) disable iff (!rst_n)
      sda_release |-> $past(tx_mode) && !tx_mode);

   p_release_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
      sda_release |-> $past(stretch_release && !shreg_write));

   p_release_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      sda_release |=> !sda_release);

   p_count_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= LAST);
endmodule

bind i2c_flag_tracker i2c_flag_tracker_chk #(
   .CLOCKS_PER_BYTE(CLOCKS_PER_BYTE), .CNT_W(CNT_W)
) i_chk (
   .clk(clk), .rst_n(rst_n), .enable(enable), .wake_mode(wake_mode),
   .stretch_release(stretch_release), .shreg_write(shreg_write),
   .ev_start(ev_start), .ev_stop(ev_stop), .ev_scl_rise(ev_scl_rise),
   .sda_s(sda_s), .bit_cnt(bit_cnt), .ack_det(ack_det), .start_det(start_det),
   .stop_det(stop_det), .tx_mode(tx_mode), .sda_release(sda_release));

// File: tb/test_i2c_flag_tracker.sv
`timescale 1ns/1ps
module test_i2c_flag_tracker;
   localparam int SYNC = 2;
   localparam int HOLD = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1, sda = 1'b1;
   logic enable = 1'b0, wake_mode = 1'b0;
   logic comm_release = 1'b0, stretch_release = 1'b0, shreg_write = 1'b0;
   logic ack_det, start_det, stop_det, tx_mode, sda_release;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #5 clk = ~clk;

   i2c_flag_tracker #(.SYNC_STAGES(SYNC)) i_i2c_flag_tracker (
      .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda), .enable(enable),
      .wake_mode(wake_mode), .comm_release(comm_release),
      .stretch_release(stretch_release), .shreg_write(shreg_write),
      .ack_det(ack_det), .start_det(start_det), .stop_det(stop_det),
      .tx_mode(tx_mode), .sda_release(sda_release));

   task automatic chk(input string req, input logic actual, input logic expected);
      n_checks++;
      if (actual !== expected) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b", req, actual, expected);
      end
   endtask

   task automatic wait_hold();
      repeat (HOLD) @(negedge clk);
   endtask

   task automatic set_sda(input logic v); @(negedge clk); sda = v; wait_hold(); endtask
   task automatic set_scl(input logic v); @(negedge clk); scl = v; wait_hold(); endtask

   task automatic pulse(ref logic sig);
      @(negedge clk); sig = 1'b1;
      @(negedge clk); sig = 1'b0;
   endtask

   task automatic bus_start(); set_sda(1'b0); set_scl(1'b0); endtask
   task automatic bus_stop(); set_sda(1'b0); set_scl(1'b1); set_sda(1'b1); endtask
   task automatic bus_bit(input logic b); set_sda(b); set_scl(1'b1); set_scl(1'b0); endtask

   task automatic send_bits(input logic [7:0] v, input int n);
      for (int i = 7; i > 7 - n; i--) bus_bit(v[i]);
   endtask

   task automatic t_reset();
      chk("R8 reset ack", ack_det, 1'b0);
      chk("R8 reset start", start_det, 1'b0);
      chk("R8 reset stop", stop_det, 1'b0);
      chk("R8 reset tx", tx_mode, 1'b0);
      chk("R8 reset sda_release", sda_release, 1'b0);
   endtask

   task automatic t_write_ack();
      bus_start();
      chk("R1 start flag", start_det, 1'b1);
      chk("R1 stop flag low", stop_det, 1'b0);
      send_bits(8'hA4, 8);             // write address, direction bit 0
      chk("R9 tx after write address", tx_mode, 1'b0);
      bus_bit(1'b0);                   // acknowledge
      chk("R2 ack set", ack_det, 1'b1);
      chk("R4 start held after address", start_det, 1'b1);
      set_sda(1'b1); set_scl(1'b1);    // first clock of data byte
      chk("R3 ack cleared at next byte", ack_det, 1'b0);
      chk("R4 start cleared at next byte", start_det, 1'b0);
      set_scl(1'b0);
      send_bits(8'h3C, 7);
      bus_bit(1'b1);                   // no acknowledge
      chk("R2 nack leaves ack low", ack_det, 1'b0);
      bus_stop();
      chk("R1 stop flag", stop_det, 1'b1);
      chk("R1 start low after stop", start_det, 1'b0);
   endtask

   task automatic t_stop_clear();
      bus_start();
      chk("R5 stop held across start", stop_det, 1'b1);
      set_sda(1'b1); set_scl(1'b1);
      chk("R5 stop cleared at first address clock", stop_det, 1'b0);
      set_scl(1'b0);
      send_bits(8'h00, 7);
      bus_bit(1'b0);
      bus_stop();
   endtask

   task automatic t_read_release();
      bus_start();
      send_bits(8'hA5, 8);             // read address, direction bit 1
      chk("R9 tx after read address", tx_mode, 1'b1);
      bus_bit(1'b0);
      chk("R2 ack on read address", ack_det, 1'b1);
      pulse(shreg_write);
      chk("R11 shift write keeps tx", tx_mode, 1'b1);
      chk("R11 shift write no release", sda_release, 1'b0);
      @(negedge clk); shreg_write = 1'b1; stretch_release = 1'b1;
      @(negedge clk); shreg_write = 1'b0; stretch_release = 1'b0;
      chk("R11 both pulses keep tx", tx_mode, 1'b1);
      chk("R11 both pulses no release", sda_release, 1'b0);
      @(negedge clk); stretch_release = 1'b1;
      @(negedge clk); stretch_release = 1'b0;
      chk("R10 tx cleared", tx_mode, 1'b0);
      chk("R10 release pulse", sda_release, 1'b1);
      @(negedge clk);
      chk("R10 release one cycle", sda_release, 1'b0);
      pulse(stretch_release);
      chk("R10 no pulse in receive", sda_release, 1'b0);
      bus_stop();
   endtask

   task automatic t_comm_release();
      bus_start();
      send_bits(8'hA5, 8);
      bus_bit(1'b0);
      pulse(comm_release);
      chk("R6 release clears ack", ack_det, 1'b0);
      chk("R6 release clears start", start_det, 1'b0);
      chk("R6 release clears tx", tx_mode, 1'b0);
      chk("R6 release keeps stop low", stop_det, 1'b0);
      bus_stop();
      pulse(comm_release);
      chk("R6 release keeps stop high", stop_det, 1'b1);
   endtask

   task automatic t_wake();
      @(negedge clk); wake_mode = 1'b1;
      @(negedge clk);
      chk("R7 wake rise no effect", stop_det, 1'b1);
      wake_mode = 1'b0;
      @(negedge clk);
      chk("R7 wake fall clears stop", stop_det, 1'b0);
   endtask

   task automatic t_priority();
      @(negedge clk); sda = 1'b0;
      repeat (SYNC) @(negedge clk);
      comm_release = 1'b1;
      @(negedge clk); comm_release = 1'b0;
      chk("R12 start wins over release", start_det, 1'b1);
      wait_hold();
      set_scl(1'b0);
      send_bits(8'h00, 8);
      bus_bit(1'b0);
      bus_stop();
   endtask

   task automatic t_enable();
      bus_start();
      chk("R8 start before disable", start_det, 1'b1);
      @(negedge clk); enable = 1'b0;
      @(negedge clk);
      chk("R8 disable clears start", start_det, 1'b0);
      set_scl(1'b1); bus_stop();
      chk("R8 stop ignored while disabled", stop_det, 1'b0);
      bus_start();
      chk("R8 start ignored while disabled", start_det, 1'b0);
      set_scl(1'b1); set_sda(1'b1);
      @(negedge clk); enable = 1'b1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      enable = 1'b1;
      wait_hold();
      t_write_ack();
      t_stop_clear();
      t_read_release();
      t_comm_release();
      t_wake();
      t_priority();
      t_enable();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule